// File: doc/BRIEF.md
# First-Order Delta-Sigma Loop Register and Boxcar Decimator

This block is the digital half of a first-order delta-sigma converter whose integrator is an external resistor-capacitor network. An off-chip comparator compares the network's node with a mid-supply reference. The comparator's output enters on `comp_i`. The block brings that bit into the clock domain and registers it, then drives the registered bit back to the network on `fb_o`. This closes a negative-feedback loop that holds the node at the reference. The fraction of clocks on which `fb_o` is high is therefore the measure of the input level.

Decimation is a single accumulate-and-dump stage. The block counts the high feedback bits over a fixed window of `WINDOW` clocks and presents that count on `result_o`, together with a one-clock `valid_o` strobe. The accumulator then starts again with no gap between windows. There is no compensation filter and no DC-blocking stage, so a constant input gives a constant count. The default window is 166,667 clocks, which gives 200 results per second from a 30 ns clock. The count is 18 bits wide at that default.

Top module: `dsm_decim`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the block clears `fb_o`, `valid_o` and `result_o` to 0 on that edge and discards any partly accumulated count.
- R2: `fb_o` equals the value `comp_i` had three clock edges earlier (two synchroniser stages, then the feedback flop), without inversion. A high comparator bit (node below the reference) therefore drives the feedback high.
- R3: `valid_o` is a one-clock pulse. After reset is released, it first goes high directly after the `WINDOW`-th rising edge. From then on it goes high exactly once every `WINDOW` clocks.
- R4: The `result_o` presented with a pulse equals the number of clocks in that window on which `fb_o` was high. The window's last clock is included, and no feedback bit is dropped or counted twice across window boundaries.
- R5: `result_o` holds its value between pulses and changes only on the edge that raises `valid_o`.
- R6: If `fb_o` stays low for a whole window, the result is 0. If it stays high for a whole window, the result is exactly `WINDOW`. `result_o` is `$clog2(WINDOW+1)` bits wide so that it can hold this value.
- R7: Within a closed loop whose integrator accumulates (input − feedback·full-scale), a constant input level L of full scale FS gives a settled result within 10 counts of L·`WINDOW`/FS. The result is the same for every window while the input is held, with no offset removal.
- R8: A reset asserted in the middle of a window throws away that window. The next pulse comes `WINDOW` clocks after the release, and its count covers only clocks after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| comp_i | input | 1 | Raw comparator bit, asynchronous to the clock |
| fb_o | output | 1 | Registered feedback bit driven to the integrator network |
| result_o | output | $clog2(WINDOW+1) | Ones count of the last complete window |
| valid_o | output | 1 | One-clock strobe marking a new `result_o` |

## Verification
Several properties are checked on every clock by the assertions:
- the three-edge delay and polarity from comparator to feedback;
- that the strobe lasts one clock and comes at the exact window period;
- that the result is held between strobes and never exceeds the window length;
- the cleared state after reset.

Other behaviour can only be shown by the bench's scenarios, where a behavioural integrator closes the loop. These are that each count matches the ones the bench itself counted on `fb_o`, that full-scale inputs give 0 and `WINDOW`, that mid-scale DC levels track within tolerance, and that a reset in mid-window restarts the count cleanly.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;

    // 33.33 MHz clock divided by 200 results per second
    parameter int unsigned DSM_DEF_WINDOW = 166_667;

    // bits needed to hold the values 0 .. n inclusive
    function automatic int unsigned count_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dsm_sync.sv
`timescale 1ns/1ps
module dsm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.chain = '0;
        end else begin
            st_d.chain = {st_q.chain[STAGES-2:0], d_i};
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/dsm_window.sv
`timescale 1ns/1ps
module dsm_window #(
    parameter int unsigned WINDOW = 166_667
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic last_o
);
    localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [WIN_W-1:0] LAST_IDX = WIN_W'(WINDOW - 1);

    typedef struct packed {
        logic [WIN_W-1:0] idx;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       at_end;

    assign at_end = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d = st_q;
        if (rst_i || at_end) begin
            st_d.idx = '0;
        end else begin
            st_d.idx = st_q.idx + WIN_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign last_o = at_end;
endmodule

// File: rtl/dsm_accum.sv
`timescale 1ns/1ps
module dsm_accum #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bit_i,
    input  logic             dump_i,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] result;
        logic             valid;
    } acc_state_t;

    acc_state_t       st_d, st_q;
    logic [CNT_W-1:0] sum;

    // the current clock's bit is always part of the running total
    assign sum = st_q.acc + CNT_W'(bit_i);

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.acc    = '0;
            st_d.result = '0;
            st_d.valid  = 1'b0;
        end else if (dump_i) begin
            st_d.result = sum;
            st_d.acc    = '0;
            st_d.valid  = 1'b1;
        end else begin
            st_d.acc    = sum;
            st_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign valid_o  = st_q.valid;
endmodule

// File: rtl/dsm_decim.sv
`timescale 1ns/1ps
module dsm_decim #(
    parameter  int unsigned WINDOW      = dsm_pkg::DSM_DEF_WINDOW,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W       = dsm_pkg::count_bits(WINDOW)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             comp_i,
    output logic             fb_o,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o
);
    typedef struct packed {
        logic fb;
    } loop_state_t;

    loop_state_t st_d, st_q;
    logic        comp_sync;
    logic        win_last;

    dsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (comp_i),
        .q_o   (comp_sync)
    );

    // feedback flop: same polarity as the comparator, so a node below the reference is pushed up
    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.fb = 1'b0;
        end else begin
            st_d.fb = comp_sync;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // the pin is the flop output itself, with no gate after it
    assign fb_o = st_q.fb;

    dsm_window #(.WINDOW(WINDOW)) u_window (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .last_o (win_last)
    );

    dsm_accum #(.CNT_W(CNT_W)) u_accum (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bit_i    (st_q.fb),
        .dump_i   (win_last),
        .result_o (result_o),
        .valid_o  (valid_o)
    );
endmodule

// File: rtl/dsm_decim_chk.sv
`timescale 1ns/1ps
module dsm_decim_chk #(
    parameter  int unsigned WINDOW      = 166_667,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W       = dsm_pkg::count_bits(WINDOW)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             comp_i,
    input logic             fb_o,
    input logic [CNT_W-1:0] result_o,
    input logic             valid_o
);
    logic [1:0] since_q;
    int unsigned period_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            since_q  <= '0;
            period_q <= 0;
        end else begin
            if (since_q != 2'd3) since_q <= since_q + 2'd1;
            period_q <= valid_o ? 1 : period_q + 1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!fb_o && !valid_o && result_o == '0));

    generate
        if (SYNC_STAGES == 2) begin : g_delay
            // R2
            loop_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (since_q == 2'd3) |-> (fb_o == $past(comp_i, 3)));
        end
    endgenerate

    // R3
    pulse_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (period_q == WINDOW) == valid_o);

    // R3
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R5
    result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (since_q != 2'd0 && !valid_o) |-> $stable(result_o));

    // R6
    result_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(result_o) <= int'(WINDOW));
endmodule

bind dsm_decim dsm_decim_chk #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .comp_i   (comp_i),
    .fb_o     (fb_o),
    .result_o (result_o),
    .valid_o  (valid_o)
);

// File: tb/dsm_decim_test.sv
`timescale 1ns/1ps
module dsm_decim_test;
    localparam int W   = 1000;
    localparam int CW  = $clog2(W + 1);
    localparam int FS  = 1024;
    localparam int TOL = 10;

    typedef struct {
        int exp;
        int lvl;
        bit dc;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          comp = 1'b0;
    logic          fb;
    logic [CW-1:0] result;
    logic          valid;

    int checks = 0;
    int fails  = 0;
    int level  = 0;
    bit done   = 1'b0;

    item_t q[$];
    longint e = 0;
    logic [2:0] ch = '0;
    int win_cnt = 0, win_n = 0, win_lvl = 0, prev_lvl = -1;
    bit win_clean = 1'b0;

    dsm_decim #(.WINDOW(W)) uut (
        .clk_i    (clk),
        .rst_i    (rst),
        .comp_i   (comp),
        .fb_o     (fb),
        .result_o (result),
        .valid_o  (valid)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // monitor + behavioural integrator: e models (reference - node)
    always @(negedge clk) begin
        if (rst) begin
            e = 0; comp = 1'b0; ch = '0;
            win_cnt = 0; win_n = 0; prev_lvl = -1;
            q.delete();
        end else begin
            check(fb == ch[2], "R2 loop delay", int'(fb), int'(ch[2]));
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(valid == 1'b1, "R3 pulse after window", int'(valid), 1);
                check(int'(result) == it.exp, "R4 window ones count", int'(result), it.exp);
                if (it.dc) begin
                    int ideal;
                    ideal = (it.lvl * W) / FS;
                    check((int'(result) - ideal <= TOL) && (ideal - int'(result) <= TOL),
                          "R7 dc tracking", int'(result), ideal);
                    if (it.lvl == 0)
                        check(int'(result) == 0, "R6 low full scale", int'(result), 0);
                    if (it.lvl == FS)
                        check(int'(result) == W, "R6 high full scale", int'(result), W);
                end
            end else if (valid) begin
                check(1'b0, "R3 unexpected pulse (R8 after reset)", 1, 0);
            end
            // count this clock's feedback bit into the bench's own window
            if (win_n == 0) begin win_lvl = level; win_clean = 1'b1; end
            if (level != win_lvl) win_clean = 1'b0;
            win_cnt += int'(fb);
            win_n++;
            if (win_n == W) begin
                item_t ni;
                ni.exp = win_cnt;
                ni.lvl = win_lvl;
                ni.dc  = win_clean && (prev_lvl == win_lvl);
                q.push_back(ni);
                prev_lvl = win_clean ? win_lvl : -1;
                win_cnt = 0; win_n = 0;
            end
            // integrator step, then comparator
            e = e + longint'(level) - (fb ? longint'(FS) : 0);
            comp = (e > 0);
            ch = {ch[1:0], comp};
        end
    end

    task automatic run_level(input int lvl, input int nwin);
        @(posedge clk); #2 level = lvl;
        repeat (nwin * W) @(posedge clk);
    endtask

    task automatic do_reset(input int ncyc);
        @(posedge clk); #2 rst = 1'b1;
        repeat (ncyc) @(posedge clk);
        #2;
        // R1 cleared state while reset held
        check(fb == 1'b0, "R1 reset fb", int'(fb), 0);
        check(valid == 1'b0, "R1 reset valid", int'(valid), 0);
        check(int'(result) == 0, "R1 reset result", int'(result), 0);
        rst = 1'b0;
    endtask

    initial begin
        do_reset(4);
        run_level(0, 3);          // R6 low
        run_level(FS, 3);         // R6 high
        run_level(FS / 2, 3);     // R7 mid scale
        run_level(256, 3);
        run_level(900, 3);
        run_level(37, 3);
        // R8 reset in the middle of a window
        @(posedge clk); #2 level = 700;
        repeat (W / 2 + 13) @(posedge clk);
        do_reset(3);
        run_level(700, 3);
        repeat (3) @(posedge clk);
        check(q.size() == 0, "R3 no pending window", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            summary();
            $finish;
        end
    end
endmodule